// File: doc/BRIEF.md
# Spin-Loop Load Detection Table

This block sits next to one core's retirement stage and watches the loads that core retires. It keeps a small fully associative table indexed by load PC. Each entry remembers the address and value the load last returned, how many times in a row that same value came back, a mark flag, and the cycle stamp at which the current run of identical values began. A load that keeps returning the same value more times than a programmable threshold is marked as a likely busy-wait load.

When a marked load finally sees a new value, the retirement logic also reports whether the change came from a write by another core, using coherence state. If it did, the block takes the wait as a confirmed spin episode. It adds the time since the run began to a saturating spin-cycle counter, pulses a one-cycle event flag, and restarts the entry so that it can track the next wait. A value change without a remote write, or on an unmarked entry, just restarts the entry. Software reads the accumulated spin cycles and turns them into a synchronization component of a per-thread cycle breakdown.

A PC that misses takes the lowest free entry. Once the table is full it replaces the least recently touched entry.

Top module: `spin_detect_table`

## Requirements
- R1: After reset the spin-cycle counter reads 0, the event flag is low and the table holds no entries, so the first load of any PC only allocates and never reports a spin.
- R2: An entry's count is the number of consecutive retired loads of its PC that returned the same address and value, counting the first one. The entry becomes marked when its count is strictly greater than the threshold, and stays marked until the entry restarts.
- R3: When a load hits a marked entry with the same address, a different value and ldRemote high, spinEvent is high for the one cycle after the load's clock edge. In that same cycle spinCycles grows by ldTs minus the entry's stored start stamp, taken modulo 2^TS_W.
- R4: A marked entry whose value changes while ldRemote is low adds nothing. The entry restarts with count 1 and the new value.
- R5: An unmarked entry whose value changes adds nothing, whatever ldRemote is, and restarts with count 1.
- R6: After a confirmed spin the entry restarts with count 1, the new value and the current stamp, so the next episode is timed from that load.
- R7: The threshold resets to DEF_THRESH. Writing cfgThresh with cfgWe high changes it for every load retired in later cycles.
- R8: A PC that misses fills the lowest-numbered empty entry. When none is empty it replaces the least recently touched entry, and the replaced PC's history is lost.
- R9: spinCycles saturates at 2^ACC_W-1 and never wraps.
- R10: In a cycle with ldValid low, the table and the counter do not change and no event is raised.
- R11: A load that hits its PC entry with a different address restarts the entry and adds nothing, even with ldRemote high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Threshold write strobe |
| cfgThresh | input | CNT_W | New repeat threshold |
| ldValid | input | 1 | A load retired this cycle |
| ldPc | input | PC_W | PC of the retired load |
| ldAddr | input | ADDR_W | Address of the retired load |
| ldData | input | DATA_W | Value the load returned |
| ldTs | input | TS_W | Current cycle stamp |
| ldRemote | input | 1 | The returned value was written by another core |
| spinCycles | output | ACC_W | Saturating accumulated spin cycles |
| spinEvent | output | 1 | One-cycle pulse per confirmed spin |

## Verification
The hardest state to reach from the ports is a marked entry that has become the least recently touched one just as a new PC forces a replacement. Only then does losing its history show up as a missing spin credit. The stimulus marks one PC, touches every other resident PC with non-remote loads, fills the free entries and then brings in a new PC. After that, a remote value change on the evicted PC must add nothing, while a marked PC that stayed resident still adds its exact elapsed time. A long randomized phase over more PCs than entries, with threshold rewrites, is compared every cycle against a behavioural model kept as a recency queue.

// File: rtl/spin_pkg.sv
package spin_pkg;
  // Strobes from the control to the entry store and accumulator
  typedef struct packed {
    logic wrEn;        // update entry wrIdx this cycle
    logic restart;     // load fresh pc/addr/data/stamp, count = 1
    logic bump;        // same value seen again: count + 1
    logic markNext;    // mark value to write (or OR in on bump)
    logic accumulate;  // confirmed spin: add elapsed time
  } spin_strobe_t;
endpackage

// File: rtl/spin_ctrl.sv
module spin_ctrl
  import spin_pkg::*;
#(
  parameter int N          = 8,
  parameter int IDX_W      = 3,
  parameter int CNT_W      = 8,
  parameter int DEF_THRESH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWe,
  input  logic [CNT_W-1:0] cfgThresh,
  input  logic             ldValid,
  input  logic             ldRemote,
  input  logic [N-1:0]     hitVec,
  input  logic [N-1:0]     validVec,
  input  logic             hitAddrSame,
  input  logic             hitDataSame,
  input  logic             hitMarked,
  input  logic [CNT_W-1:0] hitCnt,
  output spin_strobe_t     stb,
  output logic [IDX_W-1:0] wrIdx
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N - 1);

  logic [CNT_W-1:0] thresh;
  logic [IDX_W-1:0] age [N];
  logic [IDX_W-1:0] hitIdx;
  logic [IDX_W-1:0] victimIdx;
  logic             anyHit;
  logic             anyFree;
  logic [CNT_W-1:0] cntNext;

  // Programmable repeat threshold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     thresh <= CNT_W'(DEF_THRESH);
    else if (cfgWe) thresh <= cfgThresh;
  end

  // Hit encoder
  always_comb begin
    hitIdx = '0;
    anyHit = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hitVec[i]) begin
        hitIdx = IDX_W'(i);
        anyHit = 1'b1;
      end
    end
  end

  // Victim: lowest empty entry, otherwise the oldest by age
  always_comb begin
    victimIdx = '0;
    anyFree   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        victimIdx = IDX_W'(i);
        anyFree   = 1'b1;
      end
    end
    if (!anyFree) begin
      for (int i = 0; i < N; i++) begin
        if (age[i] == OLDEST) victimIdx = IDX_W'(i);
      end
    end
  end

  assign cntNext = (hitCnt == '1) ? hitCnt : hitCnt + 1'b1;

  // Decision for the retired load
  always_comb begin
    stb   = '0;
    wrIdx = anyHit ? hitIdx : victimIdx;
    if (ldValid) begin
      stb.wrEn = 1'b1;
      if (anyHit && hitAddrSame && hitDataSame) begin
        stb.bump     = 1'b1;
        stb.markNext = (cntNext > thresh);
      end else begin
        stb.restart    = 1'b1;
        stb.markNext   = (CNT_W'(1) > thresh);
        stb.accumulate = anyHit && hitAddrSame && hitMarked && ldRemote;
      end
    end
  end

  // Recency ages: a permutation of 0..N-1, 0 = most recent
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age[i] <= IDX_W'(i);
    end else if (stb.wrEn) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == wrIdx)      age[i] <= '0;
        else if (age[i] < age[wrIdx]) age[i] <= age[i] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spin_datapath.sv
module spin_datapath
  import spin_pkg::*;
#(
  parameter int N      = 8,
  parameter int IDX_W  = 3,
  parameter int PC_W   = 64,
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int TS_W   = 32,
  parameter int CNT_W  = 8,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   ldPc,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [DATA_W-1:0] ldData,
  input  logic [TS_W-1:0]   ldTs,
  input  spin_strobe_t      stb,
  input  logic [IDX_W-1:0]  wrIdx,
  output logic [N-1:0]      hitVec,
  output logic [N-1:0]      validVec,
  output logic              hitAddrSame,
  output logic              hitDataSame,
  output logic              hitMarked,
  output logic [CNT_W-1:0]  hitCnt,
  output logic [ACC_W-1:0]  spinCycles,
  output logic              spinEvent
);
  localparam int SUM_W = ((ACC_W > TS_W) ? ACC_W : TS_W) + 1;
  localparam logic [SUM_W-1:0] ACC_MAX = {{(SUM_W-ACC_W){1'b0}}, {ACC_W{1'b1}}};

  logic [PC_W-1:0]   pcTab   [N];
  logic [ADDR_W-1:0] addrTab [N];
  logic [DATA_W-1:0] dataTab [N];
  logic [TS_W-1:0]   tsTab   [N];
  logic [CNT_W-1:0]  cntTab  [N];
  logic [N-1:0]      markTab;
  logic [TS_W-1:0]   hitTs;
  logic [TS_W-1:0]   elapsed;
  logic [SUM_W-1:0]  sumWide;

  // Per-entry tag match
  for (genvar g = 0; g < N; g++) begin : g_match
    assign hitVec[g] = validVec[g] && (pcTab[g] == ldPc);
  end

  // Fields of the matching entry
  always_comb begin
    hitAddrSame = 1'b0;
    hitDataSame = 1'b0;
    hitMarked   = 1'b0;
    hitCnt      = '0;
    hitTs       = '0;
    for (int i = 0; i < N; i++) begin
      if (hitVec[i]) begin
        hitAddrSame = (addrTab[i] == ldAddr);
        hitDataSame = (dataTab[i] == ldData);
        hitMarked   = markTab[i];
        hitCnt      = cntTab[i];
        hitTs       = tsTab[i];
      end
    end
  end

  // Entry storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validVec <= '0;
      markTab  <= '0;
      for (int i = 0; i < N; i++) begin
        pcTab[i]   <= '0;
        addrTab[i] <= '0;
        dataTab[i] <= '0;
        tsTab[i]   <= '0;
        cntTab[i]  <= '0;
      end
    end else if (stb.wrEn) begin
      if (stb.restart) begin
        validVec[wrIdx] <= 1'b1;
        pcTab[wrIdx]    <= ldPc;
        addrTab[wrIdx]  <= ldAddr;
        dataTab[wrIdx]  <= ldData;
        tsTab[wrIdx]    <= ldTs;
        cntTab[wrIdx]   <= CNT_W'(1);
        markTab[wrIdx]  <= stb.markNext;
      end else if (stb.bump) begin
        if (cntTab[wrIdx] != '1) cntTab[wrIdx] <= cntTab[wrIdx] + 1'b1;
        if (stb.markNext)        markTab[wrIdx] <= 1'b1;
      end
    end
  end

  // Saturating spin-cycle accumulator
  assign elapsed = ldTs - hitTs;
  assign sumWide = SUM_W'(spinCycles) + SUM_W'(elapsed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spinCycles <= '0;
      spinEvent  <= 1'b0;
    end else begin
      spinEvent <= stb.accumulate;
      if (stb.accumulate)
        spinCycles <= (sumWide > ACC_MAX) ? ACC_MAX[ACC_W-1:0] : sumWide[ACC_W-1:0];
    end
  end
endmodule

// File: rtl/spin_detect_table.sv
module spin_detect_table
  import spin_pkg::*;
#(
  parameter int N          = 8,
  parameter int PC_W       = 64,
  parameter int ADDR_W     = 64,
  parameter int DATA_W     = 64,
  parameter int TS_W       = 32,
  parameter int CNT_W      = 8,
  parameter int ACC_W      = 32,
  parameter int DEF_THRESH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic [CNT_W-1:0]  cfgThresh,
  input  logic              ldValid,
  input  logic [PC_W-1:0]   ldPc,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [DATA_W-1:0] ldData,
  input  logic [TS_W-1:0]   ldTs,
  input  logic              ldRemote,
  output logic [ACC_W-1:0]  spinCycles,
  output logic              spinEvent
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  spin_strobe_t     stb;
  logic [IDX_W-1:0] wrIdx;
  logic [N-1:0]     hitVec;
  logic [N-1:0]     validVec;
  logic             hitAddrSame;
  logic             hitDataSame;
  logic             hitMarked;
  logic [CNT_W-1:0] hitCnt;

  spin_ctrl #(
    .N(N), .IDX_W(IDX_W), .CNT_W(CNT_W), .DEF_THRESH(DEF_THRESH)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgThresh(cfgThresh),
    .ldValid(ldValid), .ldRemote(ldRemote), .hitVec(hitVec),
    .validVec(validVec), .hitAddrSame(hitAddrSame), .hitDataSame(hitDataSame),
    .hitMarked(hitMarked), .hitCnt(hitCnt), .stb(stb), .wrIdx(wrIdx)
  );

  spin_datapath #(
    .N(N), .IDX_W(IDX_W), .PC_W(PC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .TS_W(TS_W), .CNT_W(CNT_W), .ACC_W(ACC_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .ldPc(ldPc), .ldAddr(ldAddr), .ldData(ldData),
    .ldTs(ldTs), .stb(stb), .wrIdx(wrIdx), .hitVec(hitVec), .validVec(validVec),
    .hitAddrSame(hitAddrSame), .hitDataSame(hitDataSame), .hitMarked(hitMarked),
    .hitCnt(hitCnt), .spinCycles(spinCycles), .spinEvent(spinEvent)
  );
endmodule

// File: rtl/spin_detect_table_chk.sv
module spin_detect_table_chk #(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ldValid,
  input logic             ldRemote,
  input logic [ACC_W-1:0] spinCycles,
  input logic             spinEvent
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  // R1: reset leaves the counter and the event clear
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (spinCycles == '0 && !spinEvent));

  // R3 / R4: no remote write, no spin event
  a_r3_event_needs_remote: assert property (@(posedge clk) disable iff (!rst_n)
    (ldValid && !ldRemote) |=> !spinEvent);

  // R3: the counter moves only in an event cycle
  a_r3_acc_only_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    !spinEvent |-> $stable(spinCycles));

  // R10: idle cycles change nothing
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ldValid |=> (!spinEvent && $stable(spinCycles)));

  // R9: never wraps
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    spinEvent |-> (spinCycles >= $past(spinCycles)));

  // R9: saturated value is held
  a_r9_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (spinCycles == ACC_MAX) |=> (spinCycles == ACC_MAX));
endmodule

bind spin_detect_table spin_detect_table_chk #(.ACC_W(ACC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ldValid(ldValid), .ldRemote(ldRemote),
  .spinCycles(spinCycles), .spinEvent(spinEvent)
);

// File: tb/spin_detect_table_tb_top.sv
module spin_detect_table_tb_top;
  localparam int NE = 8;
  localparam int ACC_W = 12;
  localparam longint ACC_MAX = (64'd1 << ACC_W) - 1;
  localparam int CMAX = 255;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgThresh = '0;
  logic        ldValid = 1'b0;
  logic [63:0] ldPc = '0, ldAddr = '0, ldData = '0;
  logic [31:0] ldTs = '0;
  logic        ldRemote = 1'b0;
  logic [ACC_W-1:0] spinCycles;
  logic        spinEvent;

  always #10 clk = ~clk;  // 50 MHz

  spin_detect_table #(.N(NE), .ACC_W(ACC_W), .DEF_THRESH(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgThresh(cfgThresh),
    .ldValid(ldValid), .ldPc(ldPc), .ldAddr(ldAddr), .ldData(ldData),
    .ldTs(ldTs), .ldRemote(ldRemote), .spinCycles(spinCycles), .spinEvent(spinEvent)
  );

  // Behavioural reference model
  bit          mValid [NE];
  logic [63:0] mPc [NE], mAddr [NE], mData [NE];
  int          mCnt [NE];
  bit          mMark [NE];
  logic [31:0] mTs [NE];
  int          lruQ [$];   // front = most recently touched
  int          mThr = 3;
  longint      expAcc = 0;
  bit          expEvt = 0;
  logic [31:0] tsNow = 32'd100;
  int          checks = 0, fails = 0;
  string       curReq = "R1";
  bit          compareOn = 0;
  bit          done = 0;

  task automatic chk(string req, longint act, longint exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always begin
    @(posedge clk);
    #5;
    if (compareOn && !done) begin
      chk(curReq, longint'(spinCycles), expAcc, "spinCycles per-cycle");
      chk(curReq, longint'(spinEvent), longint'(expEvt), "spinEvent per-cycle");
    end
  end

  function automatic void touch(int idx);
    foreach (lruQ[k]) if (lruQ[k] == idx) begin lruQ.delete(k); break; end
    lruQ.push_front(idx);
  endfunction

  function automatic void modelLoad(logic [63:0] pc, logic [63:0] addr,
                                    logic [63:0] data, bit remote, logic [31:0] ts);
    int hit = -1;
    int v = -1;
    expEvt = 0;
    for (int i = 0; i < NE; i++) if (mValid[i] && mPc[i] == pc) hit = i;
    if (hit >= 0) begin
      if (mAddr[hit] == addr && mData[hit] == data) begin
        if (mCnt[hit] < CMAX) mCnt[hit]++;
        if (mCnt[hit] > mThr) mMark[hit] = 1;
      end else begin
        if (mMark[hit] && remote && mAddr[hit] == addr) begin
          logic [31:0] el;
          el = ts - mTs[hit];
          expEvt = 1;
          expAcc = expAcc + longint'(el);
          if (expAcc > ACC_MAX) expAcc = ACC_MAX;
        end
        mAddr[hit] = addr; mData[hit] = data; mTs[hit] = ts;
        mCnt[hit] = 1; mMark[hit] = (1 > mThr);
      end
      touch(hit);
    end else begin
      for (int i = NE - 1; i >= 0; i--) if (!mValid[i]) v = i;
      if (v < 0) v = lruQ[$];
      mValid[v] = 1; mPc[v] = pc; mAddr[v] = addr; mData[v] = data;
      mTs[v] = ts; mCnt[v] = 1; mMark[v] = (1 > mThr);
      touch(v);
    end
  endfunction

  task automatic load(logic [63:0] pc, logic [63:0] addr, logic [63:0] data, bit remote);
    @(negedge clk);
    cfgWe = 0; ldValid = 1; ldPc = pc; ldAddr = addr; ldData = data;
    ldRemote = remote; ldTs = tsNow;
    modelLoad(pc, addr, data, remote, tsNow);
    tsNow++;
  endtask

  // R10: idle cycles drive junk on the load fields
  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cfgWe = 0; ldValid = 0; ldPc = 64'h20; ldAddr = 64'hA0;
      ldData = {$urandom, $urandom}; ldRemote = 1; ldTs = tsNow;
      expEvt = 0;
      tsNow++;
    end
  endtask

  task automatic setThresh(int t);
    @(negedge clk);
    ldValid = 0; cfgWe = 1; cfgThresh = 8'(t); ldTs = tsNow;
    expEvt = 0; mThr = t;
    tsNow++;
  endtask

  task automatic settle();
    @(posedge clk);
    #5;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    longint accA, t0, t2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    chk("R1", longint'(spinCycles), 0, "reset counter");
    chk("R1", longint'(spinEvent), 0, "reset event");
    compareOn = 1;

    // R7 default threshold 3: count 3 is not above it
    curReq = "R7";
    repeat (3) load(64'h10, 64'hA0, 64'd1, 0);
    idle(2);
    load(64'h10, 64'hA0, 64'd2, 1);
    settle();
    chk("R7", longint'(spinCycles), 0, "default threshold not reached");

    // R3 with threshold 2
    setThresh(2);
    curReq = "R3";
    t0 = tsNow;
    repeat (3) load(64'h20, 64'hB0, 64'd5, 0);
    idle(4);
    accA = tsNow - t0;
    load(64'h20, 64'hB0, 64'd6, 1);
    settle();
    chk("R3", longint'(spinEvent), 1, "spin event pulse");
    chk("R3", longint'(spinCycles), accA, "elapsed added");
    chk("R2", longint'(spinCycles), accA, "count 3 above threshold 2 marks");
    @(negedge clk); ldValid = 0; expEvt = 0; tsNow++;
    settle();
    chk("R3", longint'(spinEvent), 0, "event lasts one cycle");

    // R6 restart after spin
    curReq = "R6";
    t2 = tsNow;
    load(64'h20, 64'hB0, 64'd7, 1);
    settle();
    chk("R6", longint'(spinCycles), accA, "restarted entry unmarked");
    repeat (2) load(64'h20, 64'hB0, 64'd7, 0);
    idle(3);
    accA = accA + (tsNow - t2);
    load(64'h20, 64'hB0, 64'd8, 1);
    settle();
    chk("R6", longint'(spinCycles), accA, "timed from restart stamp");

    // R4 marked, local change
    curReq = "R4";
    repeat (3) load(64'h30, 64'hC0, 64'd1, 0);
    load(64'h30, 64'hC0, 64'd2, 0);
    settle();
    chk("R4", longint'(spinCycles), accA, "local change adds nothing");
    load(64'h30, 64'hC0, 64'd3, 1);
    settle();
    chk("R4", longint'(spinCycles), accA, "entry restarted unmarked");

    // R5 unmarked remote change (count 2 == threshold)
    curReq = "R5";
    repeat (2) load(64'h40, 64'hD0, 64'd1, 0);
    load(64'h40, 64'hD0, 64'd2, 1);
    settle();
    chk("R5", longint'(spinCycles), accA, "unmarked adds nothing");
    chk("R2", longint'(spinEvent), 0, "count equal to threshold not marked");

    // R11 address change
    curReq = "R11";
    repeat (3) load(64'h50, 64'hE0, 64'd1, 0);
    load(64'h50, 64'hE8, 64'd2, 1);
    settle();
    chk("R11", longint'(spinCycles), accA, "address change adds nothing");

    // R10 idle junk
    curReq = "R10";
    idle(5);
    settle();
    chk("R10", longint'(spinCycles), accA, "idle unchanged");

    // R8 replacement: make 0x20 marked and least recent
    curReq = "R8";
    repeat (2) load(64'h20, 64'hB0, 64'd8, 0);
    load(64'h10, 64'hA0, 64'd77, 0);
    load(64'h30, 64'hC0, 64'd77, 0);
    load(64'h40, 64'hD0, 64'd77, 0);
    load(64'h50, 64'hE8, 64'd77, 0);
    load(64'h60, 64'hF0, 64'd9, 0);
    load(64'h70, 64'hF8, 64'd9, 0);
    load(64'h80, 64'hF4, 64'd9, 0);
    load(64'h90, 64'hFC, 64'd9, 0);   // evicts 0x20
    load(64'h20, 64'hB0, 64'd99, 1);
    settle();
    chk("R8", longint'(spinCycles), accA, "evicted history lost");
    t0 = tsNow;
    repeat (3) load(64'h60, 64'hF0, 64'd4, 0);
    idle(2);
    accA = accA + (tsNow - t0);
    load(64'h60, 64'hF0, 64'd5, 1);
    settle();
    chk("R8", longint'(spinCycles), accA, "resident entry still spins");

    // Randomized phase, compared every cycle
    curReq = "R2 R3 R4 R8 random";
    for (int c = 0; c < 1500; c++) begin
      int r = $urandom_range(0, 99);
      if (r < 3) setThresh($urandom_range(0, 4));
      else if (r < 10) idle(1);
      else begin
        logic [63:0] pc;
        pc = 64'h100 + 64'($urandom_range(0, 10));
        load(pc, pc + 64'($urandom_range(0, 1)) * 8, 64'($urandom_range(0, 2)),
             $urandom_range(0, 1) == 1);
      end
    end

    // R9 saturation
    curReq = "R9";
    setThresh(0);
    load(64'h1000, 64'h2000, 64'd1, 0);
    tsNow = tsNow + 5000;
    load(64'h1000, 64'h2000, 64'd2, 1);
    settle();
    chk("R9", longint'(spinCycles), ACC_MAX, "saturated");
    load(64'h1000, 64'h2000, 64'd3, 1);
    settle();
    chk("R9", longint'(spinCycles), ACC_MAX, "holds at max");
    idle(2);
    settle();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule